// File: doc/BRIEF.md
# Overflow Interrupt Timer

A register-mapped timer with a set of identical 32-bit up-counting channels. By default there are two: one is meant to raise timed events and the other to run freely as a time base. Each channel counts up from a value that software preloads. It raises a sticky pending flag when the count wraps from all-ones to zero. It drives one interrupt line, gated by two configuration bits. To get an event after N ticks, software holds the channel in reset, preloads the all-ones value minus N, and then issues the start command.

Software reaches the registers through a single-cycle port. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address. Each channel occupies a 64-byte window, and channel c starts at byte address c*0x40. A programmable prescaler sets how fast the counter advances, as a number of input clocks per step.

Top module: `ovt_top`

## Requirements
- R1: After reset every register of every channel reads zero and every interrupt output is low.
- R2: Within a channel window the register offsets are: status 0x00, current count 0x04 (read only), control 0x10, configuration 0x20, prescale divider 0x24, and preload value 0x28. Channel c's window starts at c*0x40. Control and configuration keep only bits [1:0]. Any other offset reads zero.
- R3: While control bit 0 (hold) is 1, the count follows the preload register one cycle later and does not advance, whatever the value of control bit 1.
- R4: The count advances when control bit 1 (start) is 1, control bit 0 is 0 and configuration bit 0 (enable) is 1. After the start write, the count at the k-th following clock edge is preload + floor(k/(D+1)), where D is the divider value.
- R5: With control equal to zero, or with enable cleared, the count keeps its value.
- R6: A step from 0xFFFFFFFF wraps the count to 0 and sets status bit 0 on that same edge. Counting then continues from 0.
- R7: irq[c] is high exactly when status bit 0, configuration bit 1 (interrupt enable) and configuration bit 0 of channel c are all 1.
- R8: A status write with bit 0 set clears the pending flag. A status write with bit 0 clear has no effect. A wrap on the same edge as a clearing write leaves the flag set.
- R9: A write to one channel changes no register and no interrupt of any other channel.
- R10: The prescaler is cleared while hold is set, so with divider D the first step after start lands D+1 edges after the start write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | AW (7) | Byte address: channel index above bit 5, offset in bits [5:0] |
| bus_wdata | input | CW (32) | Write data |
| bus_rdata | output | CW (32) | Read data for bus_addr, combinational |
| irq | output | NCH (2) | Per-channel interrupt |

## Verification
A prescaler phase that was not cleared, or was compared against the wrong limit, shows up as a count off by one step at the first read after start. With a divider, that read comes within D+1 clocks. A count that misses its reload while held, or a flag that sets on the wrong step, shows on the next count or status read, and on irq in the same cycle. The preload values chosen just below all-ones bring every wrap within a few dozen clocks. Leakage between channels is visible right away, when the other window is read back after a write.

// File: rtl/ovt_pkg.sv
package ovt_pkg;
  localparam int WIN_W = 6;

  typedef enum logic [WIN_W-1:0] {
    OFS_STAT = 6'h00,
    OFS_VAL  = 6'h04,
    OFS_CTRL = 6'h10,
    OFS_CFG  = 6'h20,
    OFS_DIV  = 6'h24,
    OFS_INIT = 6'h28
  } ofs_e;

  typedef struct packed {
    logic start;
    logic hold;
  } ctrl_t;

  typedef struct packed {
    logic irq_en;
    logic en;
  } cfg_t;

  // prescale phase has reached the divider limit
  function automatic logic prescale_hit(input logic [31:0] phase, input logic [31:0] limit);
    return phase >= limit;
  endfunction

  // counter step with carry-out in the top bit
  function automatic logic [32:0] count_step(input logic [31:0] cur);
    return {1'b0, cur} + 33'd1;
  endfunction
endpackage

// File: rtl/ovt_prescaler.sv
module ovt_prescaler #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] div,
  output logic          tick
);
  import ovt_pkg::*;

  logic [CW-1:0] phase_q;
  logic          hit;

  assign hit  = prescale_hit(32'(phase_q), 32'(div));
  assign tick = adv && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (clr) begin
      phase_q <= '0;
    end else if (adv) begin
      if (hit) phase_q <= '0;
      else     phase_q <= phase_q + CW'(1);
    end
  end
endmodule

// File: rtl/ovt_channel.sv
module ovt_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stat,
  input  logic          wr_ctrl,
  input  logic          wr_cfg,
  input  logic          wr_div,
  input  logic          wr_init,
  input  logic [CW-1:0] wdata,
  output logic          flag_q,
  output logic [CW-1:0] cnt_q,
  output logic [1:0]    ctrl_bits,
  output logic [1:0]    cfg_bits,
  output logic [CW-1:0] div_q,
  output logic [CW-1:0] init_q,
  output logic          wrap_ev,
  output logic          run_ev
);
  import ovt_pkg::*;

  ctrl_t         ctrl_q;
  cfg_t          cfg_q;
  logic          hold;
  logic          tick;
  logic [32:0]   step;

  assign hold    = ctrl_q.hold;
  assign run_ev  = ctrl_q.start && !ctrl_q.hold && cfg_q.en;
  assign step    = count_step(32'(cnt_q));
  assign wrap_ev = tick && step[CW];

  assign ctrl_bits = ctrl_q;
  assign cfg_bits  = cfg_q;

  ovt_prescaler #(.CW(CW)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (hold),
    .adv  (run_ev),
    .div  (div_q),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cfg_q  <= '0;
      div_q  <= '0;
      init_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[1:0]);
      if (wr_cfg)  cfg_q  <= cfg_t'(wdata[1:0]);
      if (wr_div)  div_q  <= wdata;
      if (wr_init) init_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (hold) cnt_q <= init_q;
    else if (tick) cnt_q <= step[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (wrap_ev)             flag_q <= 1'b1;
    else if (wr_stat && wdata[0]) flag_q <= 1'b0;
  end
endmodule

// File: rtl/ovt_top.sv
module ovt_top #(
  parameter int NCH = 2,
  parameter int CW  = 32,
  localparam int AW = $clog2(NCH) + ovt_pkg::WIN_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  import ovt_pkg::*;

  logic [NCH-1:0]    flag_v;
  logic [NCH-1:0]    wrap_v;
  logic [NCH-1:0]    run_v;
  logic [NCH-1:0]    ch_sel;
  logic [2*NCH-1:0]  ctrl_v;
  logic [2*NCH-1:0]  cfg_v;
  logic [NCH*CW-1:0] cnt_v;
  logic [NCH*CW-1:0] div_v;
  logic [NCH*CW-1:0] init_v;
  logic [WIN_W-1:0]  ofs;
  logic [AW-1:0]     ch_idx;

  assign ofs    = bus_addr[WIN_W-1:0];
  assign ch_idx = bus_addr >> WIN_W;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_w;
    assign sel_w     = ch_sel[c] && bus_wr;
    assign ch_sel[c] = (ch_idx == AW'(c));

    ovt_channel #(.CW(CW)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stat  (sel_w && ofs == OFS_STAT),
      .wr_ctrl  (sel_w && ofs == OFS_CTRL),
      .wr_cfg   (sel_w && ofs == OFS_CFG),
      .wr_div   (sel_w && ofs == OFS_DIV),
      .wr_init  (sel_w && ofs == OFS_INIT),
      .wdata    (bus_wdata),
      .flag_q   (flag_v[c]),
      .cnt_q    (cnt_v[c*CW +: CW]),
      .ctrl_bits(ctrl_v[2*c +: 2]),
      .cfg_bits (cfg_v[2*c +: 2]),
      .div_q    (div_v[c*CW +: CW]),
      .init_q   (init_v[c*CW +: CW]),
      .wrap_ev  (wrap_v[c]),
      .run_ev   (run_v[c])
    );

    assign irq[c] = flag_v[c] && cfg_v[2*c] && cfg_v[2*c+1];
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_sel[c]) begin
        case (ofs)
          OFS_STAT: bus_rdata = CW'(flag_v[c]);
          OFS_VAL:  bus_rdata = cnt_v[c*CW +: CW];
          OFS_CTRL: bus_rdata = CW'(ctrl_v[2*c +: 2]);
          OFS_CFG:  bus_rdata = CW'(cfg_v[2*c +: 2]);
          OFS_DIV:  bus_rdata = div_v[c*CW +: CW];
          OFS_INIT: bus_rdata = init_v[c*CW +: CW];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ovt_checker.sv
module ovt_checker #(
  parameter int NCH = 2,
  parameter int CW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    irq,
  input logic [NCH-1:0]    flag_v,
  input logic [NCH-1:0]    wrap_v,
  input logic [NCH-1:0]    run_v,
  input logic [2*NCH-1:0]  ctrl_v,
  input logic [2*NCH-1:0]  cfg_v,
  input logic [NCH*CW-1:0] cnt_v,
  input logic [NCH*CW-1:0] init_v
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R3: held counter copies preload one cycle later
    p_hold_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_v[2*c] |=> cnt_v[c*CW +: CW] == $past(init_v[c*CW +: CW]));

    // R4: a running counter moves by at most one step per edge
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_v[c] && !ctrl_v[2*c]) |=>
        (cnt_v[c*CW +: CW] == $past(cnt_v[c*CW +: CW])) ||
        (cnt_v[c*CW +: CW] == $past(cnt_v[c*CW +: CW]) + CW'(1)));

    // R5: stopped channel keeps its count
    p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_v[2*c +: 2] == 2'b00) |=> $stable(cnt_v[c*CW +: CW]));

    // R6: wrap lands on zero and sets the flag
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[c] |=> (cnt_v[c*CW +: CW] == '0) && flag_v[c]);

    // R7: interrupt only with flag and both enables
    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> flag_v[c] && cfg_v[2*c] && cfg_v[2*c+1]);

    // R8: flag rises only after a wrap
    p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[c]) |-> $past(wrap_v[c]));
  end
endmodule

bind ovt_top ovt_checker #(.NCH(NCH), .CW(CW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .irq   (irq),
  .flag_v(flag_v),
  .wrap_v(wrap_v),
  .run_v (run_v),
  .ctrl_v(ctrl_v),
  .cfg_v (cfg_v),
  .cnt_v (cnt_v),
  .init_v(init_v)
);

// File: tb/ovt_top_bench.sv
module ovt_top_bench;
  localparam int NCH = 2;
  localparam int CW  = 32;
  localparam int AW  = 7;

  localparam logic [AW-1:0] A_STAT = 7'h00, A_VAL = 7'h04, A_CTRL = 7'h10,
                            A_CFG = 7'h20, A_DIV = 7'h24, A_INIT = 7'h28;
  localparam logic [AW-1:0] CH1 = 7'h40;

  // {preload, divider, edges after start}
  localparam int NV = 8;
  localparam logic [95:0] VEC [NV] = '{
    {32'h0000_0000, 32'd0, 32'd5},
    {32'h0000_0064, 32'd3, 32'd10},
    {32'hFFFF_FFF0, 32'd0, 32'd16},
    {32'hFFFF_FFFE, 32'd1, 32'd3},
    {32'hFFFF_FFFE, 32'd1, 32'd4},
    {32'hFFFF_FFFA, 32'd4, 32'd40},
    {32'h1234_5678, 32'd7, 32'd17},
    {32'hFFFF_FFFF, 32'd0, 32'd3}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [CW-1:0]  bus_wdata = '0;
  logic [CW-1:0]  bus_rdata;
  logic [NCH-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ovt_top #(.NCH(NCH), .CW(CW)) u_ovt_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [CW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [AW-1:0] a, input logic [CW-1:0] exp);
    logic [CW-1:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic arm(input logic [AW-1:0] b, input logic [CW-1:0] pre,
                     input logic [CW-1:0] dv, input logic [CW-1:0] cf);
    wr(b + A_CTRL, 32'd1);
    wr(b + A_STAT, 32'd1);
    wr(b + A_INIT, pre);
    wr(b + A_DIV, dv);
    wr(b + A_CFG, cf);
    wr(b + A_CTRL, 32'd2);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [CW-1:0] v1, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of both channels
    for (int c = 0; c < NCH; c++) begin
      logic [AW-1:0] b;
      b = AW'(c * 64);
      check_reg("R1 status", b + A_STAT, 0);
      check_reg("R1 count", b + A_VAL, 0);
      check_reg("R1 control", b + A_CTRL, 0);
      check_reg("R1 config", b + A_CFG, 0);
      check_reg("R1 divider", b + A_DIV, 0);
      check_reg("R1 preload", b + A_INIT, 0);
    end
    check("R1 irq", CW'(irq), 0);

    // R2: map and field widths on channel 1
    wr(CH1 + A_CTRL, 32'hFFFF_FFFF);
    wr(CH1 + A_CFG, 32'hFFFF_FFFC);
    wr(CH1 + A_DIV, 32'h0000_A5A5);
    wr(CH1 + A_INIT, 32'h0000_1357);
    @(negedge clk);
    check_reg("R2 control bits", CH1 + A_CTRL, 32'd3);
    check_reg("R2 config bits", CH1 + A_CFG, 32'd0);
    check_reg("R2 divider", CH1 + A_DIV, 32'h0000_A5A5);
    check_reg("R2 preload", CH1 + A_INIT, 32'h0000_1357);
    check_reg("R2 unmapped", CH1 + 7'h08, 32'd0);
    check_reg("R2 unmapped high", CH1 + 7'h3C, 32'd0);
    // R3: both bits set still holds at preload
    check_reg("R3 hold with start", CH1 + A_VAL, 32'h0000_1357);
    // R9: channel 0 untouched
    check_reg("R9 ch0 control", A_CTRL, 0);
    check_reg("R9 ch0 preload", A_INIT, 0);
    check_reg("R9 ch0 divider", A_DIV, 0);

    // R4 R6 R10: vector table on channel 0
    for (int i = 0; i < NV; i++) begin
      logic [CW-1:0] pre, dv, n;
      longint unsigned tot;
      {pre, dv, n} = VEC[i];
      arm(A_STAT, pre, dv, 32'd3);
      repeat (n) @(negedge clk);
      tot = longint'(pre) + longint'(n / (dv + 1));
      check_reg("R4 count after run", A_VAL, tot[31:0]);
      check_reg("R6 wrap flag", A_STAT, CW'(tot[32]));
      check("R7 irq follows flag", CW'(irq[0]), CW'(tot[32]));
    end
    check_reg("R9 ch1 count", CH1 + A_VAL, 32'h0000_1357);
    check("R9 ch1 irq", CW'(irq[1]), 0);

    // R5: control zero freezes count
    arm(A_STAT, 32'd1000, 32'd0, 32'd3);
    repeat (3) @(negedge clk);
    wr(A_CTRL, 32'd0);
    rd(A_VAL, v1);
    repeat (4) @(negedge clk);
    rd(A_VAL, v2);
    check("R5 stopped stable", v2, v1);
    check("R5 stopped value", v1, 32'd1005);
    // R5: enable cleared freezes count
    wr(A_CTRL, 32'd2);
    wr(A_CFG, 32'd2);
    rd(A_VAL, v1);
    repeat (4) @(negedge clk);
    rd(A_VAL, v2);
    check("R5 disabled stable", v2, v1);

    // R7 R8: interrupt gating and clearing
    arm(A_STAT, 32'hFFFF_FFFE, 32'd0, 32'd3);
    repeat (5) @(negedge clk);
    check_reg("R6 flag set", A_STAT, 32'd1);
    check("R7 irq high", CW'(irq[0]), 1);
    check("R9 other irq", CW'(irq[1]), 0);
    wr(A_CFG, 32'd1);
    check("R7 irq without irq enable", CW'(irq[0]), 0);
    check_reg("R7 flag kept", A_STAT, 32'd1);
    wr(A_CFG, 32'd2);
    check("R7 irq without enable", CW'(irq[0]), 0);
    wr(A_CFG, 32'd3);
    check("R7 irq restored", CW'(irq[0]), 1);
    wr(A_STAT, 32'hFFFF_FFFE);
    check_reg("R8 write zero ignored", A_STAT, 32'd1);
    wr(A_STAT, 32'd1);
    check_reg("R8 cleared", A_STAT, 32'd0);
    check("R8 irq dropped", CW'(irq[0]), 0);
    wr(A_CTRL, 32'd0);

    // R3: hold follows a new preload and does not advance
    wr(A_CTRL, 32'd1);
    wr(A_INIT, 32'd77);
    @(negedge clk);
    check_reg("R3 follows preload", A_VAL, 32'd77);
    repeat (5) @(negedge clk);
    check_reg("R3 no advance", A_VAL, 32'd77);

    // R10: first step D+1 edges after start
    arm(A_STAT, 32'd10, 32'd2, 32'd3);
    repeat (2) @(negedge clk);
    check_reg("R10 before first step", A_VAL, 32'd10);
    @(negedge clk);
    check_reg("R10 first step", A_VAL, 32'd11);

    summary();
  end
endmodule